// File: doc/BRIEF.md
# Reload Down-Counter Timer Channel

This block is one 16-bit timer channel that counts down. The counter runs on its own timer clock. Software controls it through a small register port on a separate bus clock. On every underflow the counter is reloaded from a software-written reload register. In repeat mode it then keeps counting. In one-shot mode it stops, and the run bit clears itself in hardware, so a single timed interval needs no software action to stop it.

Each underflow sets an interrupt flag. A single request line is raised while that flag is set and its enable is on. Software can preset the counter from the reload register at any time, including while the timer is stopped. Software can also read the live count. Because the count moves on the timer clock, a read taken while running is only trustworthy when two successive reads agree. A read taken while stopped is always trustworthy.

Control strobes pass into the timer domain through synchronizers. The self-clear of the run bit and each underflow event pass back to the bus domain as toggles, so no event is lost.

Top module: `reload_timer`

## Requirements
- R1: After reset, the register map reads as follows: control (offset 0) = 0, reload (offset 1) = 0, count (offset 2) = 0, interrupt (offset 3) = 0. `irq` is 0.
- R2: Writing the control register (offset 0) with bit 0 (run) = 1 starts counting. The counter decrements by one per timer clock, starting from its current value.
- R3: With control bit 1 (one-shot) = 1, the step past 0x0000 loads the reload value into the counter and stops counting. Control bit 0 then reads back 0 without a software write.
- R4: Writing control bit 0 = 0 stops counting. The count then holds its value.
- R5: With control bit 1 = 0 (repeat), the step past 0x0000 loads the reload value and counting continues. Control bit 0 stays 1.
- R6: Writing control bit 2 = 1 (preset, write-only, reads 0) copies the reload register (offset 1) into the counter. This also works while the timer is stopped.
- R7: Every underflow sets the interrupt flag (offset 3, bit 0). Writing 1 to bit 0 clears the flag. Writing 0 to bit 0 leaves it unchanged. Offset 3 bit 1 is the interrupt enable.
- R8: `irq` is 1 exactly while both the flag and the enable are 1.
- R9: The count is readable at offset 2. While the timer is stopped, successive reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| tmr_clk | input | 1 | Counter clock, independent of bus_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, one bus_clk cycle per write |
| addr | input | 2 | Register offset: 0 control, 1 reload, 2 count, 3 interrupt |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register at `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses random reload values for one-shot runs. After each run it expects the counter to rest exactly at the reload value, with the run bit clear and the flag set. A design that stops at zero, or that never clears the run bit, fails these checks.

A preset issued while the timer is stopped must land with no further counting. A design that needs a running counter to apply the preset leaves the old count in place.

The bench also checks three other cases:
- Writing 0 to the flag leaves it set. A design that clears on any write drops the flag.
- In repeat mode the run bit stays set and the count stays within the reload value. A design that stops here fails.
- An approximate elapsed-count check during a long run. A design that counts at the wrong rate is caught.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         bus_clk,
  input  logic         tmr_clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RELD = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_INT  = 2'd3;

  // bus domain state
  logic         run_q, mode_q, flag_q, ien_q;
  logic         pre_tgl, start_tgl;
  logic [W-1:0] reload_q;

  // timer domain state
  logic [W-1:0] cnt_q;
  logic         halt_q, uf_tgl, stop_tgl;

  // synchronizer chains
  logic [SYNC-1:0] run_s, mode_s;
  logic [SYNC:0]   pre_s, start_s, uf_s, stop_s;

  wire wr_ctl  = wr_en && (addr == A_CTRL);
  wire wr_reld = wr_en && (addr == A_RELD);
  wire wr_int  = wr_en && (addr == A_INT);

  wire run_t      = run_s[SYNC-1];
  wire mode_t     = mode_s[SYNC-1];
  wire pre_edge   = pre_s[SYNC] ^ pre_s[SYNC-1];
  wire start_edge = start_s[SYNC] ^ start_s[SYNC-1];
  wire uf_edge    = uf_s[SYNC] ^ uf_s[SYNC-1];
  wire stop_edge  = stop_s[SYNC] ^ stop_s[SYNC-1];

  wire count_en = run_t && !halt_q;
  wire at_zero  = (cnt_q == '0);
  wire underflow = count_en && at_zero && !pre_edge;

  // ---------------- bus domain ----------------
  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      mode_q    <= 1'b0;
      pre_tgl   <= 1'b0;
      start_tgl <= 1'b0;
    end else if (wr_ctl) begin
      run_q  <= wdata[0];
      mode_q <= wdata[1];
      if (wdata[0]) start_tgl <= ~start_tgl;
      if (wdata[2]) pre_tgl   <= ~pre_tgl;
    end else if (stop_edge) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n)       reload_q <= '0;
    else if (wr_reld) reload_q <= wdata;
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (uf_edge)                flag_q <= 1'b1;
      else if (wr_int && wdata[0]) flag_q <= 1'b0;
      if (wr_int) ien_q <= wdata[1];
    end
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_s   <= '0;
      stop_s <= '0;
    end else begin
      uf_s   <= {uf_s[SYNC-1:0], uf_tgl};
      stop_s <= {stop_s[SYNC-1:0], stop_tgl};
    end
  end

  assign irq = flag_q & ien_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata[1:0] = {mode_q, run_q};
      A_RELD: rdata = reload_q;
      A_CNT:  rdata = cnt_q;
      default: rdata[1:0] = {ien_q, flag_q};
    endcase
  end

  // ---------------- timer domain ----------------
  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_s   <= '0;
      mode_s  <= '0;
      pre_s   <= '0;
      start_s <= '0;
    end else begin
      run_s   <= {run_s[SYNC-2:0], run_q};
      mode_s  <= {mode_s[SYNC-2:0], mode_q};
      pre_s   <= {pre_s[SYNC-1:0], pre_tgl};
      start_s <= {start_s[SYNC-1:0], start_tgl};
    end
  end

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      uf_tgl   <= 1'b0;
      stop_tgl <= 1'b0;
    end else if (pre_edge) begin
      cnt_q <= reload_q;
    end else if (count_en) begin
      if (at_zero) begin
        cnt_q  <= reload_q;
        uf_tgl <= ~uf_tgl;
        if (mode_t) stop_tgl <= ~stop_tgl;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n)                    halt_q <= 1'b0;
    else if (underflow && mode_t)  halt_q <= 1'b1;
    else if (start_edge)           halt_q <= 1'b0;
  end

  // ---------------- assertions ----------------
  assert_step_down_R2: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (count_en && !at_zero && !pre_edge) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_reload_on_underflow_R5: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    underflow |=> cnt_q == $past(reload_q));

  assert_oneshot_halts_R3: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (underflow && mode_t) |=> !count_en);

  assert_hold_when_idle_R4: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (!count_en && !pre_edge) |=> $stable(cnt_q));

  assert_preset_loads_R6: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    pre_edge |=> cnt_q == $past(reload_q));

  assert_flag_set_R7: assert property (@(posedge bus_clk) disable iff (!rst_n)
    uf_edge |=> flag_q);

  assert_flag_zero_write_R7: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_int && !wdata[0] && flag_q) |=> flag_q);

  assert_flag_clear_R7: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_int && wdata[0] && !uf_edge) |=> !flag_q);

endmodule

// File: tb/reload_timer_tb.sv
module reload_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMR_PERIOD = CLK_PERIOD + 4;
  localparam int SEED       = 32'h5eed;

  logic        bus_clk = 0, tmr_clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  always #(TMR_PERIOD/2) tmr_clk = ~tmr_clk;

  reload_timer u_dut (.bus_clk, .tmr_clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .irq);

  function automatic logic [15:0] f_ctl(bit run, bit oneshot);
    return {14'd0, oneshot, run};
  endfunction
  function automatic logic [15:0] f_int(bit flag, bit en);
    return {14'd0, en, flag};
  endfunction
  function automatic logic [15:0] f_after_count(int start, int steps);
    return 16'(start - steps);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_near(string req, logic [15:0] act, logic [15:0] exp, int tol);
    int d = int'(act) - int'(exp);
    n_chk++;
    if (d > tol || d < -tol) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d +/- %0d", req, act, exp, tol);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge bus_clk); wr_en = 1; addr = a; wdata = d;
    @(negedge bus_clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    @(negedge bus_clk); addr = a; #1 v = rdata;
  endtask

  task automatic settle();
    repeat (6) @(posedge tmr_clk);
    repeat (6) @(negedge bus_clk);
  endtask

  task automatic oneshot_run(int r);
    logic [15:0] v;
    wr(2'd1, 16'(r));
    wr(2'd0, 16'h0006);
    settle();
    rd(2'd2, v); chk("R6 preset while stopped", v, 16'(r));
    wr(2'd0, f_ctl(1, 1));
    repeat (r + 8) @(posedge tmr_clk);
    settle();
    rd(2'd0, v); chk("R3 run self-clears", v, f_ctl(0, 1));
    rd(2'd2, v); chk("R3 rests at reload", v, 16'(r));
    rd(2'd3, v); chk("R7 flag set by underflow", v[0], 1'b1);
    wr(2'd3, f_int(1, 0));
    rd(2'd3, v); chk("R7 write 1 clears", v, f_int(0, 0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    n_chk++; n_bad++;
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    void'($urandom(SEED));
    #(CLK_PERIOD * 3 + 1) rst_n = 1;

    // R1 reset state
    rd(2'd0, v); chk("R1 control", v, 16'h0000);
    rd(2'd1, v); chk("R1 reload", v, 16'h0000);
    rd(2'd2, v); chk("R1 count", v, 16'h0000);
    rd(2'd3, v); chk("R1 interrupt", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // directed one-shot corners and random reloads
    oneshot_run(1);
    oneshot_run(40);
    for (int i = 0; i < 6; i++) oneshot_run(2 + int'($urandom % 60));

    // R2 / R4: elapsed count during a long run, then hold
    wr(2'd1, 16'd300);
    wr(2'd0, 16'h0004);
    settle();
    wr(2'd0, f_ctl(1, 0));
    repeat (50) @(posedge tmr_clk);
    wr(2'd0, f_ctl(0, 0));
    settle();
    rd(2'd2, v); chk_near("R2 decrement per timer clock", v, f_after_count(300, 50), 5);
    repeat (40) @(posedge tmr_clk);
    rd(2'd2, v2); chk("R4 count held while stopped", v2, v);
    rd(2'd2, v2); chk("R9 stopped reads agree", v2, v);

    // R2 resume from held value, not from reload
    wr(2'd0, f_ctl(1, 0));
    repeat (20) @(posedge tmr_clk);
    wr(2'd0, f_ctl(0, 0));
    settle();
    rd(2'd2, v2); chk_near("R2 resumes from current count", v2, f_after_count(int'(v), 20), 5);

    // R5 repeat mode
    wr(2'd3, f_int(1, 0));
    wr(2'd1, 16'd4);
    wr(2'd0, 16'h0004);
    settle();
    wr(2'd0, f_ctl(1, 0));
    repeat (60) @(posedge tmr_clk);
    settle();
    rd(2'd0, v); chk("R5 run stays set", v, f_ctl(1, 0));
    rd(2'd3, v); chk("R7 flag set in repeat", v[0], 1'b1);
    wr(2'd0, f_ctl(0, 0));
    settle();
    rd(2'd2, v); chk("R5 count within reload", {15'd0, v <= 16'd4}, 16'd1);

    // R7 write 0 no effect, R8 irq gating
    wr(2'd3, f_int(0, 0));
    rd(2'd3, v); chk("R7 write 0 keeps flag", v, f_int(1, 0));
    chk("R8 irq off when disabled", {15'd0, irq}, 16'd0);
    wr(2'd3, f_int(0, 1));
    @(negedge bus_clk);
    chk("R8 irq on with flag and enable", {15'd0, irq}, 16'd1);
    wr(2'd3, f_int(1, 1));
    @(negedge bus_clk);
    chk("R8 irq off after clear", {15'd0, irq}, 16'd0);
    rd(2'd3, v); chk("R7 enable kept", v, f_int(0, 1));

    // R6 preset while running in repeat mode overrides count
    wr(2'd1, 16'd1000);
    wr(2'd0, 16'h0005);
    repeat (10) @(posedge tmr_clk);
    wr(2'd0, f_ctl(0, 0));
    settle();
    rd(2'd2, v); chk_near("R6 preset while running", v, 16'd995, 10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule